// File: doc/BRIEF.md
# PLL output rate calculator

This block derives the output frequency of a fractional-N synthesizer from its reference frequency and the raw words that hold its programming fields. It works from the integer multiplier, from the numerator and denominator of the fractional part, and from an optional post-divider field. A single start pulse latches the reference and the four words. The block then runs a fixed sequence of multiply, divide and accumulate steps. It presents the rate on `rate_o` together with a one-cycle `done_o` pulse.

Each raw word is masked down to its field width before use. The integer part is the reference times the multiplier. The fractional part is the reference times the numerator, divided by the denominator, and it is left out when the denominator is zero. When the post-divider is built in (`PDIV_W` > 0), the sum is divided by the post-divider field plus one.

Both divisions share one restoring divider that produces one quotient bit per cycle. The divider width is sized so that no intermediate value loses precision. Only the final result is cut to `OUT_W` bits.

Top module: `pll_rate_calc`

## Requirements
- R1: Only bits [9:0] of `l_i` form the integer multiplier; bits above them have no effect on the result.
- R2: Only bits [18:0] of `m_i` and of `n_i` form the numerator and denominator. A denominator whose only set bits lie above bit 18 counts as zero.
- R3: The integer part of the rate is `ref_i` times the masked multiplier, computed without loss.
- R4: With a nonzero masked denominator, the term floor(`ref_i` × M / N) is added to the integer part. The product `ref_i` × M is kept at full width (at least 51 bits) before the division.
- R5: With a zero masked denominator, no fractional term is added, whatever the numerator holds.
- R6: With `PDIV_W` > 0, the post-divider field is `cfg_i[PDIV_SHIFT +: PDIV_W]` (bits [21:20] by default), and the sum is divided by field+1 with truncation. With `PDIV_W` = 0, `cfg_i` has no effect and no post-division takes place.
- R7: `rate_o` carries the low `OUT_W` bits of the full-precision result.
- R8: `done_o` is high for exactly one cycle per accepted start. `rate_o` changes only in that cycle and holds its value until the next `done_o`.
- R9: A start is accepted only while `busy_o` is low. `busy_o` is high from the cycle after acceptance until the cycle of `done_o`. A `start_i` pulse while busy is ignored and produces no extra result. The operands are latched at acceptance.
- R10: Each division takes one cycle per quotient bit, so `done_o` follows an accepted start within 2×ACC_W+8 cycles.
- R11: After reset, `busy_o` and `done_o` are low and `rate_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| ref_i | input | REF_W | Reference frequency |
| l_i | input | WORD_W | Raw word holding the integer multiplier |
| m_i | input | WORD_W | Raw word holding the fractional numerator |
| n_i | input | WORD_W | Raw word holding the fractional denominator |
| cfg_i | input | WORD_W | Raw word holding the post-divider field |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result strobe |
| rate_o | output | OUT_W | Computed output rate |

## Verification
The bench builds two copies of the block side by side and feeds them identical stimulus. The first copy uses the default two-bit post-divider at bit 20, so dividing by 1 to 4 with noisy neighbouring bits in the config word can be reached. The second copy uses `PDIV_W` = 0, which shows that the same config word then leaves the rate untouched and that the short sequence skips the second division. With a 32-bit reference and the widest multiplier and numerator, the sum exceeds 2^42, which makes the final truncation and the full-width product visible.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FRAC,
    ST_SUM,
    ST_POST
  } calc_st_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pll_rate_fields.sv
module pll_rate_fields #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned L_W        = 10,
  parameter int unsigned MN_W       = 19,
  parameter int unsigned PDIV_SHIFT = 20,
  parameter int unsigned PDIV_W     = 2,
  localparam int unsigned PD_W      = (PDIV_W > 0) ? PDIV_W : 1
) (
  input  logic [WORD_W-1:0] l_i,
  input  logic [WORD_W-1:0] m_i,
  input  logic [WORD_W-1:0] n_i,
  input  logic [WORD_W-1:0] cfg_i,
  output logic [L_W-1:0]    l_o,
  output logic [MN_W-1:0]   m_o,
  output logic [MN_W-1:0]   n_o,
  output logic [PD_W-1:0]   pdiv_o
);

  localparam logic [WORD_W-1:0] L_MASK  = (WORD_W'(1) << L_W) - WORD_W'(1);
  localparam logic [WORD_W-1:0] MN_MASK = (WORD_W'(1) << MN_W) - WORD_W'(1);

  assign l_o = L_W'(l_i & L_MASK);
  assign m_o = MN_W'(m_i & MN_MASK);
  assign n_o = MN_W'(n_i & MN_MASK);

  generate
    if (PDIV_W > 0) begin : g_pdiv
      localparam logic [WORD_W-1:0] PD_MASK = (WORD_W'(1) << PDIV_W) - WORD_W'(1);
      assign pdiv_o = PD_W'((cfg_i >> PDIV_SHIFT) & PD_MASK);
    end else begin : g_no_pdiv
      logic unused_cfg;
      assign unused_cfg = ^cfg_i;
      assign pdiv_o     = '0;
    end
  endgenerate

endmodule

// File: rtl/pll_rate_div.sv
// Restoring divider, one quotient bit per cycle.
module pll_rate_div #(
  parameter int unsigned DVD_W = 52,
  parameter int unsigned DVS_W = 19,
  localparam int unsigned CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);

  logic [DVD_W-1:0] q_q;
  logic [DVS_W-1:0] rem_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;

  logic [DVS_W:0]   rem_sh;
  logic [DVS_W+1:0] diff;
  logic             fits;

  assign rem_sh = {rem_q, q_q[DVD_W-1]};
  assign diff   = {1'b0, rem_sh} - {2'b00, dvs_q};
  assign fits   = ~diff[DVS_W+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      q_q    <= dvd_i;
      rem_q  <= '0;
      dvs_q  <= dvs_i;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      q_q   <= {q_q[DVD_W-2:0], fits};
      rem_q <= fits ? diff[DVS_W-1:0] : rem_sh[DVS_W-1:0];
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(DVD_W - 1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_rate_pkg::*;
#(
  parameter int unsigned REF_W      = 32,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned L_W        = 10,
  parameter int unsigned MN_W       = 19,
  parameter int unsigned PDIV_SHIFT = 20,
  parameter int unsigned PDIV_W     = 2,
  parameter int unsigned OUT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REF_W-1:0]  ref_i,
  input  logic [WORD_W-1:0] l_i,
  input  logic [WORD_W-1:0] m_i,
  input  logic [WORD_W-1:0] n_i,
  input  logic [WORD_W-1:0] cfg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [OUT_W-1:0]  rate_o
);

  localparam int unsigned ACC_W    = REF_W + max_u(L_W, MN_W) + 1;
  localparam int unsigned PD_W     = (PDIV_W > 0) ? PDIV_W : 1;
  localparam int unsigned DVS_W    = max_u(MN_W, PDIV_W + 1);
  localparam bit          HAS_POST = (PDIV_W > 0);

  logic [L_W-1:0]  l_f;
  logic [MN_W-1:0] m_f, n_f;
  logic [PD_W-1:0] pd_f;

  pll_rate_fields #(
    .WORD_W(WORD_W), .L_W(L_W), .MN_W(MN_W),
    .PDIV_SHIFT(PDIV_SHIFT), .PDIV_W(PDIV_W)
  ) u_fields (
    .l_i(l_i), .m_i(m_i), .n_i(n_i), .cfg_i(cfg_i),
    .l_o(l_f), .m_o(m_f), .n_o(n_f), .pdiv_o(pd_f)
  );

  calc_st_e         st_q;
  logic [REF_W-1:0] ref_q;
  logic [L_W-1:0]   l_q;
  logic [MN_W-1:0]  m_q, n_q;
  logic [PD_W-1:0]  pd_q;
  logic [ACC_W-1:0] acc_q;
  logic [OUT_W-1:0] rate_q;
  logic             done_q;

  logic             div_load, div_done;
  logic [ACC_W-1:0] div_dvd, div_quot;
  logic [DVS_W-1:0] div_dvs;

  always_comb begin
    div_load = 1'b0;
    div_dvd  = ACC_W'(ref_q) * ACC_W'(m_q);
    div_dvs  = DVS_W'(n_q);
    if (st_q == ST_LOAD && n_q != '0) begin
      div_load = 1'b1;
    end else if (st_q == ST_SUM && HAS_POST) begin
      div_load = 1'b1;
      div_dvd  = acc_q;
      div_dvs  = DVS_W'(pd_q) + DVS_W'(1);
    end
  end

  pll_rate_div #(.DVD_W(ACC_W), .DVS_W(DVS_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(div_load),
    .dvd_i(div_dvd), .dvs_i(div_dvs),
    .done_o(div_done), .quot_o(div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ref_q  <= '0;
      l_q    <= '0;
      m_q    <= '0;
      n_q    <= '0;
      pd_q   <= '0;
      acc_q  <= '0;
      rate_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          ref_q <= ref_i;
          l_q   <= l_f;
          m_q   <= m_f;
          n_q   <= n_f;
          pd_q  <= pd_f;
          st_q  <= ST_LOAD;
        end
        ST_LOAD: begin
          acc_q <= ACC_W'(ref_q) * ACC_W'(l_q);
          st_q  <= (n_q != '0) ? ST_FRAC : ST_SUM;
        end
        ST_FRAC: if (div_done) begin
          acc_q <= acc_q + div_quot;
          st_q  <= ST_SUM;
        end
        ST_SUM: begin
          if (HAS_POST) begin
            st_q <= ST_POST;
          end else begin
            rate_q <= acc_q[OUT_W-1:0];
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_POST: if (div_done) begin
          rate_q <= div_quot[OUT_W-1:0];
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign rate_o = rate_q;

endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
  parameter int unsigned OUT_W   = 32,
  parameter int unsigned MAX_LAT = 112
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [OUT_W-1:0] rate_o
);

  int unsigned lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= 0;
    else if (busy_o) lat_q <= lat_q + 1;
    else lat_q <= 0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rate_o)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o)); // R9
  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R9
  AST_LATENCY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q <= MAX_LAT); // R10

endmodule

bind pll_rate_calc pll_rate_calc_chk #(
  .OUT_W(OUT_W),
  .MAX_LAT(2 * ACC_W + 8)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .rate_o(rate_o)
);

// File: tb/pll_rate_calc_tb_top.sv
module pll_rate_calc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_w = '0, l_w = '0, m_w = '0, n_w = '0, cfg_w = '0;

  logic        busy_a, done_a, busy_b, done_b;
  logic [31:0] rate_a, rate_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] q_a[$], q_b[$];
  string       t_a[$], t_b[$];
  logic [31:0] last_a = '0, last_b = '0;
  logic        prev_done_a = 1'b0, prev_done_b = 1'b0;

  always #4 clk = ~clk;

  pll_rate_calc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ref_i(ref_w), .l_i(l_w), .m_i(m_w), .n_i(n_w), .cfg_i(cfg_w),
    .busy_o(busy_a), .done_o(done_a), .rate_o(rate_a)
  );

  pll_rate_calc #(.PDIV_W(0)) dut_np_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ref_i(ref_w), .l_i(l_w), .m_i(m_w), .n_i(n_w), .cfg_i(cfg_w),
    .busy_o(busy_b), .done_o(done_b), .rate_o(rate_b)
  );

  function automatic logic [31:0] model(input logic [31:0] r, l, m, n, cfg, input int pw);
    longint unsigned lv, mv, nv, acc, pd;
    lv  = 64'(l & 32'h3ff);
    mv  = 64'(m & 32'h7ffff);
    nv  = 64'(n & 32'h7ffff);
    acc = 64'(r) * lv;
    if (nv != 0) acc = acc + (64'(r) * mv) / nv;
    if (pw > 0) begin
      pd  = (64'(cfg) >> 20) & ((64'd1 << pw) - 1);
      acc = acc / (pd + 1);
    end
    return acc[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_a) begin
        if (prev_done_a) chk("R8 done width A", 32'd1, 32'd0);
        if (q_a.size() == 0) chk("R9 unexpected result A", rate_a, 32'hx);
        else begin
          chk(t_a.pop_front(), rate_a, q_a[0]);
          last_a = q_a.pop_front();
        end
      end
      if (done_b) begin
        if (prev_done_b) chk("R8 done width B", 32'd1, 32'd0);
        if (q_b.size() == 0) chk("R9 unexpected result B", rate_b, 32'hx);
        else begin
          chk(t_b.pop_front(), rate_b, q_b[0]);
          last_b = q_b.pop_front();
        end
      end
      prev_done_a = done_a;
      prev_done_b = done_b;
    end
  end

  task automatic run(input string req, input logic [31:0] r, l, m, n, cfg);
    chk("R8 rate held A", rate_a, last_a);
    chk("R8 rate held B", rate_b, last_b);
    q_a.push_back(model(r, l, m, n, cfg, 2));
    t_a.push_back({req, " (post-div build)"});
    q_b.push_back(model(r, l, m, n, cfg, 0));
    t_b.push_back({req, " (no post-div build)"});
    ref_w = r; l_w = l; m_w = m; n_w = n; cfg_w = cfg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy_a || busy_b) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy A", {31'd0, busy_a}, 32'd0);
    chk("R11 done A", {31'd0, done_a}, 32'd0);
    chk("R11 rate A", rate_a, 32'd0);
    chk("R11 rate B", rate_b, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R3 R5 integer only", 32'd19_200_000, 32'd52, 32'd0, 32'd0, 32'd0);
    run("R4 fraction", 32'd27_000_000, 32'd40, 32'd1, 32'd3, 32'd0);
    run("R1 upper L bits ignored", 32'd19_200_000, 32'hFFFF_FC05, 32'd0, 32'd0, 32'd0);
    run("R2 R5 N above bit 18 is zero", 32'd1000, 32'd3, 32'd77, 32'h0008_0000, 32'd0);
    run("R2 upper M N bits ignored", 32'd48_000_000, 32'd20, 32'hFFF8_0007, 32'hFFF8_0009, 32'd0);
    run("R6 post-div field 3 noisy cfg", 32'd38_400_000, 32'd62, 32'd5, 32'd8, 32'hA5B5_1234);
    run("R6 post-div field 1", 32'd38_400_000, 32'd62, 32'd5, 32'd8, 32'h0010_0000);
    run("R6 post-div field 2 truncation", 32'd1001, 32'd1, 32'd0, 32'd0, 32'hFFEF_FFFF);
    run("R4 R7 wide product truncated", 32'hFFFF_FFFF, 32'h3FF, 32'h7FFFF, 32'd1, 32'd0);
    run("R4 R6 R7 full-scale fraction", 32'hFFFF_FFFF, 32'h3FF, 32'h7FFFF, 32'h7FFFF, 32'h0010_0000);
    run("R3 zero reference", 32'd0, 32'h3FF, 32'd9, 32'd2, 32'h0030_0000);
    run("R5 zero numerator", 32'd25_000_000, 32'd32, 32'd0, 32'd5, 32'd0);
    for (int i = 0; i < 8; i++) begin
      run("R4 R6 mixed", $urandom, $urandom, $urandom, $urandom | 32'd1, $urandom);
    end

    // R9: start while busy is ignored, operands latched at acceptance
    chk("R8 rate held A", rate_a, last_a);
    q_a.push_back(model(32'd19_200_000, 32'd50, 32'd7, 32'd11, 32'h0020_0000, 2));
    t_a.push_back("R9 start while busy ignored (post-div build)");
    q_b.push_back(model(32'd19_200_000, 32'd50, 32'd7, 32'd11, 32'h0020_0000, 0));
    t_b.push_back("R9 start while busy ignored (no post-div build)");
    ref_w = 32'd19_200_000; l_w = 32'd50; m_w = 32'd7; n_w = 32'd11; cfg_w = 32'h0020_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 busy after accept", {31'd0, busy_a}, 32'd1);
    ref_w = 32'd1; l_w = 32'd2; m_w = 32'd3; n_w = 32'd4; cfg_w = 32'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy_a || busy_b) @(negedge clk);
    repeat (300) @(negedge clk);
    chk("R9 no extra result A", 32'(q_a.size()), 32'd0);
    chk("R9 no extra result B", 32'(q_b.size()), 32'd0);
    chk("R8 rate held after idle A", rate_a, last_a);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule